// File: doc/BRIEF.md
# Real-time counter with shared prescaler

This block is an 8-bit free-running event counter for a small processor core. Each clock cycle it can advance on one of two event sources: the core's instruction-cycle tick, or a qualifying edge on an external input pin. The pin is brought into the clock domain through a two-stage synchroniser and then passed through an edge detector whose polarity is selectable, so every qualifying edge produces exactly one count event.

A single 8-bit prescaler is shared between the counter and a watchdog. When the prescaler is given to the counter, it divides the chosen event source by 2^(k+1), where k is a 3-bit field, so the ratio runs from 1:2 to 1:256. The watchdog tick then follows the instruction-cycle tick at 1:1. When the prescaler is given to the watchdog, the counter counts every source event, and the prescaler divides the instruction-cycle tick into the watchdog tick.

When the counter wraps from FFh to 00h and the interrupt is enabled, a sticky request flag is set. The flag stays set until the core clears it. The core can also load the counter at any time, and a load always clears the prescaler.

Top module: `cycle_event_counter`

## Requirements
- R1: While `rstN` is low, `cntValue` is 00h and `irqReq` is 0. The prescaler is also cleared.
- R2: The option byte fields are: bits [2:0] = divide select k; bit 3 = prescaler owner (0 counter, 1 watchdog); bit 4 = edge polarity (0 rising, 1 falling); bit 5 = source (0 instruction tick, 1 pin); bit 6 = interrupt disable (active high); bit 7 is ignored. With bit 5 = 0 and bit 3 = 1, the counter advances by exactly one for each cycle in which `cycleTick` is high.
- R3: With bit 5 = 1, `cycleTick` has no effect on the counter. With bit 4 = 0, each rising edge of `extPin` advances the counter by one.
- R4: With bit 5 = 1 and bit 4 = 1, only falling edges count. The count becomes visible on the third rising clock edge after the pin changes.
- R5: With bit 3 = 0, the counter advances once per 2^(k+1) source events, counted from the last prescaler clear.
- R6: With bit 3 = 1, `wdtTick` is high in one `cycleTick` cycle out of every 2^(k+1), counted from the last prescaler clear. The counter runs at 1:1.
- R7: With bit 3 = 0, `wdtTick` equals `cycleTick`.
- R8: A cycle with `cntWrEn` high loads `cntWrData` into the counter, overriding any increment in that cycle, and clears the prescaler.
- R9: An increment from FFh to 00h with bit 6 = 0 sets `irqReq` on the same clock edge.
- R10: An increment from FFh to 00h with bit 6 = 1 leaves `irqReq` at 0.
- R11: `irqReq` stays set until a cycle with `irqClr` high clears it. If a new wrap happens in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleTick | input | 1 | Instruction-cycle enable, one cycle wide per instruction |
| extPin | input | 1 | Asynchronous external count input |
| optCfg | input | 8 | Option byte (fields in R2) |
| cntWrEn | input | 1 | Core write strobe for the counter |
| cntWrData | input | 8 | Value to load into the counter |
| irqClr | input | 1 | Clears the wrap request flag |
| cntValue | output | 8 | Current counter value |
| irqReq | output | 1 | Sticky wrap interrupt request |
| wdtTick | output | 1 | Watchdog base tick, prescaled or 1:1 |

## Verification
The properties assume that `optCfg` changes only between events, that `cycleTick` is a plain level sampled each clock, and that `extPin` stays at each level for at least two clocks so that no edge is lost in the synchroniser. The directed stimulus changes `extPin` only on falling clock edges and holds every pin level for two or more cycles. It also rewrites the option byte only while no events are in flight, and loads the counter to clear the prescaler before any ratio is measured, so every expected count starts from a known phase.

// File: rtl/rtcnt_pkg.sv
package rtcnt_pkg;

  // option byte field positions
  localparam int OPT_DIV_LSB   = 0;
  localparam int OPT_DIV_W     = 3;
  localparam int OPT_PRE_WDT   = 3;
  localparam int OPT_EDGE_FALL = 4;
  localparam int OPT_SRC_PIN   = 5;
  localparam int OPT_IRQ_OFF   = 6;
  localparam int OPT_W         = 8;

  typedef struct packed {
    logic preInc;
    logic preClr;
    logic cntInc;
    logic cntLoad;
    logic irqSet;
    logic irqClr;
  } rtcnt_strobe_t;

endpackage

// File: rtl/rtcnt_pin_sync.sv
module rtcnt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinRise,
  output logic pinFall
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], pinIn};
  end

  assign pinRise =  chain[STAGES-1] & ~chain[STAGES];
  assign pinFall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/rtcnt_ctrl.sv
module rtcnt_ctrl
  import rtcnt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 8
) (
  input  logic                cycleTick,
  input  logic                pinRise,
  input  logic                pinFall,
  input  logic [OPT_W-1:0]    optCfg,
  input  logic [PRE_W-1:0]    preCnt,
  input  logic [CNT_W-1:0]    cntValue,
  input  logic                cntWrEn,
  input  logic                irqClr,
  output rtcnt_strobe_t       stb,
  output logic                wdtTick
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [OPT_DIV_W-1:0] divSel;
  logic                 preToWdt, edgeFall, srcPin, irqOff;
  logic                 unusedOptBit;
  logic                 pinEv, srcEv, preHit;
  logic [PRE_W-1:0]     divMask;

  assign divSel       = optCfg[OPT_DIV_LSB +: OPT_DIV_W];
  assign preToWdt     = optCfg[OPT_PRE_WDT];
  assign edgeFall     = optCfg[OPT_EDGE_FALL];
  assign srcPin       = optCfg[OPT_SRC_PIN];
  assign irqOff       = optCfg[OPT_IRQ_OFF];
  assign unusedOptBit = optCfg[OPT_W-1];

  // low (k+1) bits set: ratio 2^(k+1)
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      divMask[i] = (i <= int'(divSel));
    end
  end

  assign pinEv  = edgeFall ? pinFall : pinRise;
  assign srcEv  = srcPin ? pinEv : cycleTick;
  assign preHit = ((preCnt & divMask) == divMask);

  always_comb begin
    stb         = '0;
    stb.cntLoad = cntWrEn;
    stb.preClr  = cntWrEn;
    stb.irqClr  = irqClr;
    if (preToWdt) begin
      stb.preInc = cycleTick;
      stb.cntInc = srcEv & ~cntWrEn;
      wdtTick    = cycleTick & preHit;
    end else begin
      stb.preInc = srcEv;
      stb.cntInc = srcEv & preHit & ~cntWrEn;
      wdtTick    = cycleTick;
    end
    stb.irqSet = stb.cntInc & (cntValue == CNT_TOP) & ~irqOff;
  end
endmodule

// File: rtl/rtcnt_dp.sv
module rtcnt_dp
  import rtcnt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcnt_strobe_t     stb,
  input  logic [CNT_W-1:0]  cntWrData,
  output logic [PRE_W-1:0]  preCnt,
  output logic [CNT_W-1:0]  cntValue,
  output logic              irqFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           preCnt <= '0;
    else if (stb.preClr) preCnt <= '0;
    else if (stb.preInc) preCnt <= preCnt + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntValue <= '0;
    else if (stb.cntLoad) cntValue <= cntWrData;
    else if (stb.cntInc)  cntValue <= cntValue + CNT_W'(1);
  end

  // a new wrap wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           irqFlag <= 1'b0;
    else if (stb.irqSet) irqFlag <= 1'b1;
    else if (stb.irqClr) irqFlag <= 1'b0;
  end
endmodule

// File: rtl/cycle_event_counter.sv
module cycle_event_counter
  import rtcnt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleTick,
  input  logic             extPin,
  input  logic [7:0]       optCfg,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             irqClr,
  output logic [CNT_W-1:0] cntValue,
  output logic             irqReq,
  output logic             wdtTick
);
  logic             pinRise, pinFall;
  logic [PRE_W-1:0] preCnt;
  rtcnt_strobe_t    stb;

  rtcnt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn(extPin),
    .pinRise(pinRise), .pinFall(pinFall)
  );

  rtcnt_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ctrl (
    .cycleTick(cycleTick), .pinRise(pinRise), .pinFall(pinFall),
    .optCfg(optCfg), .preCnt(preCnt), .cntValue(cntValue),
    .cntWrEn(cntWrEn), .irqClr(irqClr), .stb(stb), .wdtTick(wdtTick)
  );

  rtcnt_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntWrData(cntWrData),
    .preCnt(preCnt), .cntValue(cntValue), .irqFlag(irqReq)
  );
endmodule

// File: rtl/rtcnt_chk.sv
module rtcnt_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycleTick,
  input logic [7:0]       optCfg,
  input logic             cntWrEn,
  input logic [CNT_W-1:0] cntWrData,
  input logic             irqClr,
  input logic [CNT_W-1:0] cntValue,
  input logic             irqReq,
  input logic             wdtTick
);
  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> cntValue == $past(cntWrData));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntWrEn |=> (cntValue == $past(cntValue)) || (cntValue == $past(cntValue) + CNT_W'(1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWrEn && !cycleTick && !optCfg[5]) |=> $stable(cntValue));

  // R9
  irq_on_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> ($past(cntValue) == '1) && (cntValue == '0));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (optCfg[6] && !irqReq) |=> !irqReq);

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqClr) |=> irqReq);

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && cntValue != '1) |=> !irqReq);

  // R6
  wdt_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtTick |-> cycleTick);
endmodule

bind cycle_event_counter rtcnt_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cycle_event_counter_tb.sv
module cycle_event_counter_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycleTick = 1'b0;
  logic       extPin = 1'b0;
  logic [7:0] optCfg = 8'h00;
  logic       cntWrEn = 1'b0;
  logic [7:0] cntWrData = 8'h00;
  logic       irqClr = 1'b0;
  logic [7:0] cntValue;
  logic       irqReq;
  logic       wdtTick;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cycle_event_counter u_dut (
    .clk(clk), .rstN(rstN), .cycleTick(cycleTick), .extPin(extPin),
    .optCfg(optCfg), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .irqClr(irqClr), .cntValue(cntValue), .irqReq(irqReq), .wdtTick(wdtTick)
  );

  // option byte helper: k, owner, falling, pin source, irq off
  function automatic logic [7:0] opt(int k, bit wdt, bit fall, bit pin, bit off);
    return {1'b0, off, pin, fall, wdt, 3'(k)};
  endfunction

  task automatic check(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin @(negedge clk); cycleTick = 1'b1; end
    @(negedge clk); cycleTick = 1'b0;
  endtask

  task automatic load(logic [7:0] v);
    @(negedge clk); cntWrEn = 1'b1; cntWrData = v;
    @(negedge clk); cntWrEn = 1'b0;
  endtask

  task automatic test_reset();
    check("R1 count", int'(cntValue), 0);
    check("R1 irq", int'(irqReq), 0);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic test_cycle_source();
    optCfg = opt(0, 1, 0, 0, 1);
    load(8'h10);
    ticks(5);
    check("R2 five ticks", int'(cntValue), 8'h15);
    optCfg = opt(0, 1, 0, 0, 1) | 8'h80;
    ticks(3);
    check("R2 bit7 ignored", int'(cntValue), 8'h18);
    idle(3);
    check("R2 hold", int'(cntValue), 8'h18);
  endtask

  task automatic test_pin_rise();
    optCfg = opt(0, 1, 0, 1, 1);
    load(8'h00);
    @(negedge clk); cycleTick = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); extPin = 1'b1;
      idle(2);
      extPin = 1'b0;
      idle(1);
    end
    idle(4);
    cycleTick = 1'b0;
    check("R3 rising edges", int'(cntValue), 3);
  endtask

  task automatic test_pin_fall();
    optCfg = opt(0, 1, 1, 1, 1);
    load(8'h40);
    @(negedge clk); extPin = 1'b1;
    idle(4);
    check("R4 rise ignored", int'(cntValue), 8'h40);
    extPin = 1'b0;
    idle(2);
    check("R4 before latency", int'(cntValue), 8'h40);
    idle(1);
    check("R4 after latency", int'(cntValue), 8'h41);
  endtask

  task automatic test_divide();
    optCfg = opt(1, 0, 0, 0, 1);
    load(8'h00);
    ticks(7);
    check("R5 div4 seven", int'(cntValue), 1);
    ticks(1);
    check("R5 div4 eight", int'(cntValue), 2);
    optCfg = opt(7, 0, 0, 0, 1);
    load(8'h00);
    ticks(255);
    check("R5 div256 minus one", int'(cntValue), 0);
    ticks(1);
    check("R5 div256", int'(cntValue), 1);
  endtask

  task automatic test_wdt_owner();
    int pulses = 0;
    int firstAt = -1;
    optCfg = opt(2, 1, 0, 0, 1);
    load(8'h00);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); cycleTick = 1'b1;
      #1;
      if (wdtTick) begin
        pulses++;
        if (firstAt < 0) firstAt = i;
      end
    end
    @(negedge clk); cycleTick = 1'b0;
    check("R6 wdt pulses", pulses, 2);
    check("R6 first pulse", firstAt, 7);
    check("R6 counter 1:1", int'(cntValue), 16);
  endtask

  task automatic test_wdt_bypass();
    int pulses = 0;
    optCfg = opt(3, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); cycleTick = 1'b1;
      #1;
      if (wdtTick) pulses++;
    end
    @(negedge clk); cycleTick = 1'b0;
    #1;
    check("R7 wdt follows tick", pulses, 5);
    check("R7 wdt low", int'(wdtTick), 0);
  endtask

  task automatic test_write();
    optCfg = opt(1, 0, 0, 0, 1);
    load(8'h00);
    ticks(3);
    load(8'h10);
    ticks(3);
    check("R8 prescaler cleared", int'(cntValue), 8'h10);
    ticks(1);
    check("R8 after clear", int'(cntValue), 8'h11);
    optCfg = opt(0, 1, 0, 0, 1);
    @(negedge clk); cntWrEn = 1'b1; cntWrData = 8'h20; cycleTick = 1'b1;
    @(negedge clk); cntWrEn = 1'b0; cycleTick = 1'b0;
    check("R8 write wins", int'(cntValue), 8'h20);
  endtask

  task automatic test_irq();
    optCfg = opt(0, 1, 0, 0, 0);
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
    load(8'hFE);
    ticks(1);
    check("R9 no irq at FF", int'(irqReq), 0);
    ticks(1);
    check("R9 wrap value", int'(cntValue), 0);
    check("R9 irq set", int'(irqReq), 1);
    idle(3);
    check("R11 sticky", int'(irqReq), 1);
    load(8'hFF);
    @(negedge clk); cycleTick = 1'b1; irqClr = 1'b1;
    @(negedge clk); cycleTick = 1'b0; irqClr = 1'b0;
    check("R11 set wins", int'(irqReq), 1);
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
    check("R11 cleared", int'(irqReq), 0);
    optCfg = opt(0, 1, 0, 0, 1);
    load(8'hFF);
    ticks(1);
    check("R10 wrap value", int'(cntValue), 0);
    check("R10 masked", int'(irqReq), 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    idle(3);
    test_reset();
    test_cycle_source();
    test_pin_rise();
    test_pin_fall();
    test_divide();
    test_wdt_owner();
    test_wdt_bypass();
    test_write();
    test_irq();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule